// File: doc/BRIEF.md
# Serial Flash Command Guard

This block decides which commands a serial NOR flash slave may carry out, and it keeps that slave's protection state. It watches the chip-select, clock and data-in lines of an SPI mode-0 link. It samples them with the system clock, counts the bits in each chip-select frame and decodes the first byte as the opcode. It also collects a 3-byte address and a status data byte. The block owns a write-enable latch, a status-lock bit and two region-protect bits. It samples a write-protect pin and tracks a deep power-down state.

When a frame ends, each command that would change stored data passes a set of checks. The checks are the frame length, the write-enable latch, the protected region, the pin lock, power-down, the power-up delay and whether an earlier command is still busy. An accepted command produces a one-cycle go strobe with an operation code and an address. A busy counter then models its run time. The status byte is available in parallel at all times, and it is also shifted out serially for a read-status command.

Top module: `flash_guard`

## Requirements
- R1: The write-enable latch (status bit 1) is set only by opcode 06h. A write-status (01h), page-program (02h), sector-erase (D8h) or bulk-erase (C7h) frame is executed only while the latch is 1; otherwise it is dropped and nothing changes.
- R2: The latch is cleared by opcode 04h and when an accepted modifying command completes; a rejected modifying command leaves it unchanged.
- R3: A modifying command is executed only if chip select rises after a whole, non-zero number of bytes (bit count a multiple of eight).
- R4: Opcode B9h enters deep power-down (dpd_o=1). In that state every frame is ignored except opcode ABh, which leaves it.
- R5: The region-protect field (status bits 3:2) blocks program and sector erase according to the top address bits of an 18-bit address: 00 protects nothing, 01 protects addresses with bits 17:16 = 11, 10 protects addresses with bit 17 = 1, and 11 protects everything.
- R6: Bulk erase is rejected whenever the region-protect field is non-zero.
- R7: While the status-lock bit (status bit 7) is 1 and wp_n is low, a write-status command is rejected and bits 7:2 of the status do not change.
- R8: No modifying command is accepted until PUW_CYCLES clocks have passed after reset.
- R9: After an acceptance, write-in-progress (status bit 0) stays set for at least BUSY_CYCLES clocks. While it is set, every frame is ignored.
- R10: The status byte is {lock, 3'b000, protect[1:0], latch, in-progress}. After opcode 05h it is shifted out on spi_miso, MSB first, changing on SCK falling edges.
- R11: Each acceptance pulses go_o for exactly one clock. go_op_o gives 0 for write-status, 1 for page program, 2 for sector erase and 3 for bulk erase. go_addr_o gives the low 18 bits of the frame address.
- R12: After reset the status byte is 00h, dpd_o is 0 and go_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | SPI data into the slave |
| wp_n | input | 1 | Write-protect pin, active low |
| spi_miso | output | 1 | SPI data out of the slave (status readback) |
| stat_o | output | 8 | Current status byte |
| dpd_o | output | 1 | Deep power-down state |
| go_o | output | 1 | One-cycle strobe for an accepted modifying command |
| go_op_o | output | 2 | Operation of the accepted command |
| go_addr_o | output | ADDR_W | Address of the accepted command |

## Verification
Some rules are checked on every cycle. An acceptance needs the latch set beforehand, may not happen in power-down, while busy or before the power-up delay, and may not hit a protected region or bulk-erase with protection on. The go strobe lasts one cycle, the latch is clear when in-progress falls, and the lock bits stay frozen while the pin lock holds. Other behaviour shows only in the bench's command sequences: which frames are rejected for their length, and that the latch survives a rejection. The bench also shows that power-down entry and release are ignored at the right times, what the serial readback contains, and the operation code and address reported with each strobe.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_SE   = 8'hD8;
  localparam logic [7:0] OPC_BE   = 8'hC7;
  localparam logic [7:0] OPC_DP   = 8'hB9;
  localparam logic [7:0] OPC_RES  = 8'hAB;

  typedef enum logic [1:0] {
    GO_WRSR = 2'd0,
    GO_PP   = 2'd1,
    GO_SE   = 2'd2,
    GO_BE   = 2'd3
  } go_op_e;
endpackage

// File: rtl/fg_spi_rx.sv
module fg_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       byte_vld,
  output logic [7:0] byte_dat,
  output logic [2:0] byte_idx,
  output logic       frame_end,
  output logic       frame_aligned,
  output logic [2:0] frame_bytes,
  output logic       fall_edge
);
  localparam int SL = SYNC_STAGES;

  logic [SL-1:0] cs_sy, sck_sy, mosi_sy;
  logic          cs_d, sck_d;
  logic [2:0]    bitc, nbytes;
  logic [6:0]    sh;
  logic          rise, cs_rise, cs_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sy   <= '1;
      sck_sy  <= '0;
      mosi_sy <= '0;
      cs_d    <= 1'b1;
      sck_d   <= 1'b0;
    end else begin
      cs_sy   <= {cs_sy[SL-2:0], cs_n};
      sck_sy  <= {sck_sy[SL-2:0], sck};
      mosi_sy <= {mosi_sy[SL-2:0], mosi};
      cs_d    <= cs_sy[SL-1];
      sck_d   <= sck_sy[SL-1];
    end
  end

  assign rise      = sck_sy[SL-1] & ~sck_d & ~cs_sy[SL-1];
  assign fall_edge = ~sck_sy[SL-1] & sck_d & ~cs_sy[SL-1];
  assign cs_rise   = cs_sy[SL-1] & ~cs_d;
  assign cs_fall   = ~cs_sy[SL-1] & cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitc          <= '0;
      nbytes        <= '0;
      sh            <= '0;
      byte_vld      <= 1'b0;
      byte_dat      <= '0;
      byte_idx      <= '0;
      frame_end     <= 1'b0;
      frame_aligned <= 1'b0;
      frame_bytes   <= '0;
    end else begin
      byte_vld  <= 1'b0;
      frame_end <= 1'b0;
      if (cs_fall) begin
        bitc   <= '0;
        nbytes <= '0;
      end else if (rise) begin
        sh   <= {sh[5:0], mosi_sy[SL-1]};
        bitc <= bitc + 3'd1;
        if (bitc == 3'd7) begin
          byte_vld <= 1'b1;
          byte_dat <= {sh, mosi_sy[SL-1]};
          byte_idx <= nbytes;
          if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
        end
      end
      if (cs_rise) begin
        frame_end     <= 1'b1;
        frame_aligned <= (bitc == 3'd0) && (nbytes != 3'd0);
        frame_bytes   <= nbytes;
      end
    end
  end
endmodule

// File: rtl/fg_timer.sv
module fg_timer #(
  parameter int CYCLES       = 16,
  parameter bit LOAD_ON_RST  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(CYCLES);

  logic [CW-1:0] cnt;

  generate
    if (LOAD_ON_RST) begin : g_rst_load
      always_ff @(posedge clk) begin
        if (rst)              cnt <= LOADV;
        else if (start)       cnt <= LOADV;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
      end
    end else begin : g_idle_rst
      always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (start)       cnt <= LOADV;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
      end
    end
  endgenerate

  assign busy = (cnt != '0);
endmodule

// File: rtl/fg_core.sv
module fg_core
  import fg_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  input  logic [2:0]        byte_idx,
  input  logic              frame_end,
  input  logic              frame_aligned,
  input  logic [2:0]        frame_bytes,
  input  logic              fall_edge,
  input  logic              wp_n,
  input  logic              por_busy,
  input  logic              busy_run,
  output logic [7:0]        stat,
  output logic              dpd,
  output logic              go,
  output go_op_e            go_op,
  output logic [ADDR_W-1:0] go_addr,
  output logic              miso
);
  localparam int MSB = ADDR_W - 1;

  logic [7:0]        opc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        wr_q;
  logic              wel_q, srwd_q, wip_q, dpd_q, rd_q, miso_q, go_q;
  logic [1:0]        bp_q;
  logic [7:0]        rsh_q;
  go_op_e            op_q, op_sel;
  logic [ADDR_W-1:0] gaddr_q;
  logic              prot, mod_ok, acc, live;

  assign stat = {srwd_q, 3'b000, bp_q, wel_q, wip_q};

  // region check on the collected address
  always_comb begin
    unique case (bp_q)
      2'b01:   prot = &addr_q[MSB -: 2];
      2'b10:   prot = addr_q[MSB];
      2'b11:   prot = 1'b1;
      default: prot = 1'b0;
    endcase
  end

  // acceptance decision for modifying opcodes
  always_comb begin
    mod_ok = frame_aligned && wel_q && !por_busy;
    acc    = 1'b0;
    op_sel = GO_WRSR;
    case (opc_q)
      OPC_WRSR: begin
        op_sel = GO_WRSR;
        acc    = mod_ok && (frame_bytes >= 3'd2) && !(srwd_q && !wp_n);
      end
      OPC_PP: begin
        op_sel = GO_PP;
        acc    = mod_ok && (frame_bytes >= 3'd5) && !prot;
      end
      OPC_SE: begin
        op_sel = GO_SE;
        acc    = mod_ok && (frame_bytes >= 3'd4) && !prot;
      end
      OPC_BE: begin
        op_sel = GO_BE;
        acc    = mod_ok && (bp_q == 2'b00);
      end
      default: acc = 1'b0;
    endcase
  end

  assign live = frame_end && !dpd_q && !wip_q && (frame_bytes != 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q   <= '0;
      addr_q  <= '0;
      wr_q    <= '0;
      wel_q   <= 1'b0;
      srwd_q  <= 1'b0;
      bp_q    <= '0;
      wip_q   <= 1'b0;
      dpd_q   <= 1'b0;
      rd_q    <= 1'b0;
      rsh_q   <= '0;
      miso_q  <= 1'b0;
      go_q    <= 1'b0;
      op_q    <= GO_WRSR;
      gaddr_q <= '0;
    end else begin
      go_q <= 1'b0;

      if (byte_vld) begin
        case (byte_idx)
          3'd0: begin
            opc_q <= byte_dat;
            if (byte_dat == OPC_RDSR && !dpd_q) begin
              rd_q  <= 1'b1;
              rsh_q <= stat;
            end
          end
          3'd1: begin
            addr_q <= {addr_q[ADDR_W-9:0], byte_dat};
            wr_q   <= {byte_dat[7], byte_dat[3:2]};
          end
          3'd2, 3'd3: addr_q <= {addr_q[ADDR_W-9:0], byte_dat};
          default: ;
        endcase
      end

      if (fall_edge && rd_q) begin
        miso_q <= rsh_q[7];
        rsh_q  <= {rsh_q[6:0], rsh_q[7]};
      end

      // completion: busy counter has run out after the strobe
      if (wip_q && !busy_run && !go_q) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
      end

      if (frame_end) begin
        rd_q   <= 1'b0;
        miso_q <= 1'b0;
        if (dpd_q) begin
          if (frame_bytes != 3'd0 && opc_q == OPC_RES) dpd_q <= 1'b0;
        end else if (live) begin
          case (opc_q)
            OPC_WREN: wel_q <= 1'b1;
            OPC_WRDI: wel_q <= 1'b0;
            OPC_DP:   dpd_q <= 1'b1;
            default: begin
              if (acc) begin
                go_q    <= 1'b1;
                op_q    <= op_sel;
                gaddr_q <= addr_q;
                wip_q   <= 1'b1;
                if (opc_q == OPC_WRSR) {srwd_q, bp_q} <= wr_q;
              end
            end
          endcase
        end
      end
    end
  end

  assign dpd     = dpd_q;
  assign go      = go_q;
  assign go_op   = op_q;
  assign go_addr = gaddr_q;
  assign miso    = miso_q;
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int PUW_CYCLES  = 300,
  parameter int BUSY_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              wp_n,
  output logic              spi_miso,
  output logic [7:0]        stat_o,
  output logic              dpd_o,
  output logic              go_o,
  output logic [1:0]        go_op_o,
  output logic [ADDR_W-1:0] go_addr_o
);
  logic       byte_vld, frame_end, frame_aligned, fall_edge;
  logic [7:0] byte_dat;
  logic [2:0] byte_idx, frame_bytes;
  logic       por_busy, busy_run;
  go_op_e     op_w;

  fg_spi_rx #(.SYNC_STAGES(2)) u_rx (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_idx(byte_idx),
    .frame_end(frame_end), .frame_aligned(frame_aligned),
    .frame_bytes(frame_bytes), .fall_edge(fall_edge)
  );

  fg_timer #(.CYCLES(PUW_CYCLES), .LOAD_ON_RST(1'b1)) u_por (
    .clk(clk), .rst(rst), .start(1'b0), .busy(por_busy)
  );

  fg_timer #(.CYCLES(BUSY_CYCLES), .LOAD_ON_RST(1'b0)) u_busy (
    .clk(clk), .rst(rst), .start(go_o), .busy(busy_run)
  );

  fg_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst(rst),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_idx(byte_idx),
    .frame_end(frame_end), .frame_aligned(frame_aligned),
    .frame_bytes(frame_bytes), .fall_edge(fall_edge),
    .wp_n(wp_n), .por_busy(por_busy), .busy_run(busy_run),
    .stat(stat_o), .dpd(dpd_o), .go(go_o), .go_op(op_w),
    .go_addr(go_addr_o), .miso(spi_miso)
  );

  assign go_op_o = op_w;
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int ADDR_W      = 18,
  parameter int PUW_CYCLES  = 300,
  parameter int BUSY_CYCLES = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              wp_n,
  input logic [7:0]        stat_o,
  input logic              dpd_o,
  input logic              go_o,
  input logic [1:0]        go_op_o,
  input logic [ADDR_W-1:0] go_addr_o
);
  logic [31:0] por_cnt, wip_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      por_cnt <= '0;
      wip_cnt <= '0;
    end else begin
      if (por_cnt != 32'hFFFF_FFFF) por_cnt <= por_cnt + 1;
      if (!stat_o[0]) wip_cnt <= '0;
      else            wip_cnt <= wip_cnt + 1;
    end
  end

  function automatic logic hit_f(input logic [1:0] bp, input logic [ADDR_W-1:0] a);
    case (bp)
      2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
      2'b10:   return a[ADDR_W-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assert_go_needs_latch_R1: assert property (@(posedge clk) disable iff (rst)
    go_o |-> $past(stat_o[1]));
  assert_latch_clear_on_done_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_o[0]) |-> !stat_o[1]);
  assert_no_go_in_sleep_R4: assert property (@(posedge clk) disable iff (rst)
    go_o |-> !$past(dpd_o));
  assert_no_protected_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (go_o && (go_op_o == 2'd1 || go_op_o == 2'd2)) |-> !hit_f($past(stat_o[3:2]), go_addr_o));
  assert_bulk_unprotected_R6: assert property (@(posedge clk) disable iff (rst)
    (go_o && go_op_o == 2'd3) |-> ($past(stat_o[3:2]) == 2'b00));
  assert_pin_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_o[7] && !wp_n) |=> (stat_o[7:2] == $past(stat_o[7:2])));
  assert_powerup_wait_R8: assert property (@(posedge clk) disable iff (rst)
    go_o |-> (por_cnt >= PUW_CYCLES));
  assert_go_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    go_o |-> !$past(stat_o[0]));
  assert_busy_length_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_o[0]) |-> (wip_cnt >= BUSY_CYCLES));
  assert_go_single_R11: assert property (@(posedge clk) disable iff (rst)
    go_o |=> !go_o);
endmodule

bind flash_guard fg_checker #(
  .ADDR_W(ADDR_W), .PUW_CYCLES(PUW_CYCLES), .BUSY_CYCLES(BUSY_CYCLES)
) u_fg_checker (
  .clk(clk), .rst(rst), .wp_n(wp_n), .stat_o(stat_o), .dpd_o(dpd_o),
  .go_o(go_o), .go_op_o(go_op_o), .go_addr_o(go_addr_o)
);

// File: tb/test_flash_guard.sv
`timescale 1ns/1ps
module test_flash_guard;
  localparam int ADDR_W = 18;
  localparam int PUW    = 300;
  localparam int BUSY   = 200;
  localparam int NV     = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, wp_n = 1'b1;
  logic spi_miso, dpd_o, go_o;
  logic [7:0] stat_o;
  logic [1:0] go_op_o;
  logic [ADDR_W-1:0] go_addr_o;

  int checks = 0;
  int errors = 0;
  int go_cnt = 0;
  logic [1:0] last_op;
  logic [ADDR_W-1:0] last_addr;

  always #10 clk = ~clk;

  flash_guard #(.ADDR_W(ADDR_W), .PUW_CYCLES(PUW), .BUSY_CYCLES(BUSY)) i_flash_guard (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .wp_n(wp_n), .spi_miso(spi_miso), .stat_o(stat_o),
    .dpd_o(dpd_o), .go_o(go_o), .go_op_o(go_op_o), .go_addr_o(go_addr_o)
  );

  always_ff @(posedge clk) begin
    if (go_o) begin
      go_cnt    <= go_cnt + 1;
      last_op   <= go_op_o;
      last_addr <= go_addr_o;
    end
  end

  // {req[3:0], wp_n, nbits[7:0], data[47:0], exp_stat[7:0], exp_go, exp_dpd}
  localparam logic [70:0] VEC [NV] = '{
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h02, 1'b0, 1'b0}, // R1 set latch
    {4'd2,  1'b1, 8'd32, 48'hD8_0300_0000_00, 8'h00, 1'b1, 1'b0}, // R2 erase done clears latch
    {4'd1,  1'b1, 8'd40, 48'h02_0001_00AA_00, 8'h00, 1'b0, 1'b0}, // R1 no latch
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h02, 1'b0, 1'b0}, // R1
    {4'd3,  1'b1, 8'd41, 48'h02_0001_00AA_80, 8'h02, 1'b0, 1'b0}, // R3 41 bits
    {4'd10, 1'b1, 8'd16, 48'h01_8400_0000_00, 8'h84, 1'b1, 1'b0}, // R10 layout
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h86, 1'b0, 1'b0}, // R1
    {4'd5,  1'b1, 8'd32, 48'hD8_0300_0000_00, 8'h86, 1'b0, 1'b0}, // R5 top quarter
    {4'd5,  1'b1, 8'd32, 48'hD8_0200_0000_00, 8'h84, 1'b1, 1'b0}, // R5 open
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h86, 1'b0, 1'b0}, // R1
    {4'd6,  1'b1, 8'd8,  48'hC7_0000_0000_00, 8'h86, 1'b0, 1'b0}, // R6
    {4'd7,  1'b0, 8'd16, 48'h01_0000_0000_00, 8'h86, 1'b0, 1'b0}, // R7 pin lock
    {4'd7,  1'b1, 8'd16, 48'h01_0800_0000_00, 8'h08, 1'b1, 1'b0}, // R7 pin high
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h0A, 1'b0, 1'b0}, // R1
    {4'd5,  1'b1, 8'd40, 48'h02_0200_0055_00, 8'h0A, 1'b0, 1'b0}, // R5 upper half
    {4'd5,  1'b1, 8'd40, 48'h02_0100_0055_00, 8'h08, 1'b1, 1'b0}, // R5 lower half
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h0A, 1'b0, 1'b0}, // R1
    {4'd2,  1'b1, 8'd8,  48'h04_0000_0000_00, 8'h08, 1'b0, 1'b0}, // R2 disable
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h0A, 1'b0, 1'b0}, // R1
    {4'd10, 1'b1, 8'd16, 48'h01_0C00_0000_00, 8'h0C, 1'b1, 1'b0}, // R10
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h0E, 1'b0, 1'b0}, // R1
    {4'd5,  1'b1, 8'd40, 48'h02_0000_0011_00, 8'h0E, 1'b0, 1'b0}, // R5 whole array
    {4'd3,  1'b1, 8'd31, 48'hD8_0000_0000_00, 8'h0E, 1'b0, 1'b0}, // R3 31 bits
    {4'd2,  1'b1, 8'd16, 48'h01_0000_0000_00, 8'h00, 1'b1, 1'b0}, // R2
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h02, 1'b0, 1'b0}, // R1
    {4'd6,  1'b1, 8'd8,  48'hC7_0000_0000_00, 8'h00, 1'b1, 1'b0}, // R6 allowed
    {4'd4,  1'b1, 8'd8,  48'hB9_0000_0000_00, 8'h00, 1'b0, 1'b1}, // R4 enter
    {4'd4,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h00, 1'b0, 1'b1}, // R4 ignored
    {4'd4,  1'b1, 8'd8,  48'hAB_0000_0000_00, 8'h00, 1'b0, 1'b0}, // R4 release
    {4'd1,  1'b1, 8'd8,  48'h06_0000_0000_00, 8'h02, 1'b0, 1'b0}  // R1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] d, input int nb, output logic [47:0] rx);
    rx = '0;
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      spi_mosi = d[47-i];
      repeat (4) @(negedge clk);
      rx[47-i] = spi_miso;
      spi_sck = 1'b1;
      repeat (4) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] rx;
    int g0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 status", {24'd0, stat_o}, 32'h00);
    chk("R12 dpd", {31'd0, dpd_o}, 32'd0);
    chk("R12 go", {31'd0, go_o}, 32'd0);

    // R8: latch set, bulk erase inside the power-up window
    send(48'h06_0000_0000_00, 8, rx);
    g0 = go_cnt;
    send(48'hC7_0000_0000_00, 8, rx);
    repeat (4) @(negedge clk);
    chk("R8 no go", go_cnt - g0, 32'd0);
    chk("R8 status", {24'd0, stat_o}, 32'h02);
    repeat (PUW) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [70:0] v;
      v = VEC[k];
      wp_n = v[66];
      g0 = go_cnt;
      send(v[57:10], int'(v[65:58]), rx);
      repeat (BUSY + 20) @(negedge clk);
      chk($sformatf("R%0d vec%0d status", v[70:67], k), {24'd0, stat_o}, {24'd0, v[9:2]});
      chk($sformatf("R%0d vec%0d go", v[70:67], k), go_cnt - g0, {31'd0, v[1]});
      chk($sformatf("R%0d vec%0d dpd", v[70:67], k), {31'd0, dpd_o}, {31'd0, v[0]});
      wp_n = 1'b1;
    end

    // R9/R11: accepted erase, then power-down request while busy
    g0 = go_cnt;
    send(48'hD8_0200_0000_00, 32, rx);
    repeat (4) @(negedge clk);
    chk("R9 busy status", {24'd0, stat_o}, 32'h03);
    chk("R11 go count", go_cnt - g0, 32'd1);
    chk("R11 op", {30'd0, last_op}, 32'd2);
    chk("R11 addr", {14'd0, last_addr}, 32'h20000);
    send(48'hB9_0000_0000_00, 8, rx);
    chk("R9 ignored while busy", {31'd0, dpd_o}, 32'd0);
    repeat (BUSY + 20) @(negedge clk);
    chk("R9 done status", {24'd0, stat_o}, 32'h00);

    // R10: serial readback of status
    send(48'h06_0000_0000_00, 8, rx);
    send(48'h05_0000_0000_00, 16, rx);
    chk("R10 miso byte", {24'd0, rx[39:32]}, 32'h02);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule